// File: doc/BRIEF.md
# Programmable-Timing Asynchronous Memory Controller

This block turns single read and write requests from an on-chip bus into cycles on an external asynchronous memory port. Each external access is split into a setup phase, a strobe phase and a hold phase. The number of interface clock periods in each phase is programmable. Reads and writes have independent settings, and every chip-select space carries its own six-field timing word.

On the internal side, a request is presented with a valid/ready handshake. It carries a chip-select index, a write flag, a word address, byte enables and write data. Completion is a one-cycle done pulse, which also carries the captured read data. On the external side the block drives one active-low chip enable per space, a word address, active-low byte enables, an active-low output enable, active-low read and write strobes, and a data bus split into output, drive enable and input. An asynchronous ready input is synchronized inside the block. When it reports not-ready at the end of the programmed strobe, the strobe phase is stretched.

The timing word of chip select k sits at bits [26k+25 : 26k] of `cs_timing_i`. Its read half holds setup in [3:0], strobe in [9:4] and hold in [12:10]. Its write half uses the same layout shifted up by 13 bits.

Top module: `amc_ctrl`

## Requirements
- R1: While reset is held and right after it is released, every chip enable, the read strobe, the write strobe and the output enable are high, `mem_dq_oe_o` is low, `done_o` is low and `req_ready_o` is high.
- R2: For a read, the select signals are active for exactly S periods before the read strobe goes low, the strobe stays low for T periods and the select signals stay active for H periods after it rises. S, T and H come from the read half of the accessed space's timing word (setup [3:0], strobe [9:4], hold [12:10]).
- R3: A write follows the same three-phase sequence on the write strobe, using the write half of the timing word (setup [16:13], strobe [22:17], hold [25:23]). The output enable stays high throughout a write.
- R4: A timing field programmed to zero behaves as a length of one period.
- R5: During a write, `mem_dq_oe_o` is high with the request's write data on `mem_dq_o` from the second setup period through the last hold period, so data leads the write strobe by S−1 periods. It is low at all other times, including all of every read.
- R6: The ready input passes through a two-stage synchronizer and is looked at only in the last programmed strobe period. Each not-ready sample there adds one strobe period; a not-ready level seen only earlier in the strobe has no effect.
- R7: Read data is taken from `mem_dq_i` at the clock edge that ends the strobe phase and is presented on `done_rdata_o` while `done_o` is high.
- R8: `done_o` is a single-period pulse in the period after the last hold period. A request presented in that period is accepted at once, so accesses can run back to back.
- R9: `req_ready_o` is low from the period after an acceptance until the access's done period.
- R10: In the done period of a read, `req_ready_o` is low if `req_we_i` is 1 and high if it is 0, so a following write starts one period later than a following read would.
- R11: During an access, only the chip enable of the requested index is low. `mem_addr_o` equals the request address, and `mem_be_no` is the inverse of the request byte enables; all three are held for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_timing_i | input | 26*NUM_CS | Per-space timing words, read half low, write half high |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_cs_i | input | CS_W | Chip-select index of the request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_be_i | input | DW/8 | Byte enables, active high |
| req_wdata_i | input | DW | Write data |
| done_o | output | 1 | One-period completion pulse |
| done_rdata_o | output | DW | Read data, valid with done_o |
| mem_ce_no | output | NUM_CS | Chip enables, active low |
| mem_addr_o | output | AW | External word address |
| mem_be_no | output | DW/8 | Byte enables, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_rd_no | output | 1 | Read strobe, active low |
| mem_wr_no | output | 1 | Write strobe, active low |
| mem_dq_o | output | DW | Data bus output value |
| mem_dq_oe_o | output | 1 | Data bus driver enable |
| mem_dq_i | input | DW | Data bus input value |
| mem_rdy_i | input | 1 | Asynchronous ready, high = ready |

## Verification
Completion of one access and acceptance of the next can fall in the same period. The done pulse of the finishing access coincides with the idle period in which `req_ready_o` may admit the following request. The bench provokes this by presenting the next request in the very period where `done_o` is seen, after reads and after writes, and counts how many periods pass before acceptance. Zero waits are expected after a write or before a read; exactly one wait is expected when a write follows a read. A second overlap checked is read capture against hold: the bench changes `mem_dq_i` in the first hold period and expects the value from the strobe phase.

// File: rtl/amc_pkg.sv
package amc_pkg;

   // Field widths of one direction (read or write) of a timing word
   localparam int SETUP_W  = 4;
   localparam int STROBE_W = 6;
   localparam int HOLD_W   = 3;
   localparam int DIR_W    = SETUP_W + STROBE_W + HOLD_W;
   localparam int CFG_W    = 2 * DIR_W;
   // Phase counter width covers the widest field
   localparam int CNT_W    = STROBE_W;

   // Packed so that setup sits at the low bits of the direction half
   typedef struct packed {
      logic [HOLD_W-1:0]   hold;
      logic [STROBE_W-1:0] strobe;
      logic [SETUP_W-1:0]  setup;
   } dir_field_t;

   // Effective (zero-clamped) lengths, all in counter width
   typedef struct packed {
      logic [CNT_W-1:0] setup;
      logic [CNT_W-1:0] strobe;
      logic [CNT_W-1:0] hold;
   } eff_len_t;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_STROBE = 2'd2,
      ST_HOLD   = 2'd3
   } cyc_state_t;

   function automatic logic [CNT_W-1:0] min_one(input logic [CNT_W-1:0] v);
      return (v == '0) ? CNT_W'(1) : v;
   endfunction

endpackage

// File: rtl/amc_ready_sync.sv
module amc_ready_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("amc_ready_sync: at least two stages are needed");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/amc_timing_sel.sv
module amc_timing_sel
   import amc_pkg::*;
#(
   parameter  int NUM_CS = 4,
   localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic [NUM_CS*CFG_W-1:0] cfg_i,
   input  logic [CS_W-1:0]         cs_i,
   input  logic                    we_i,
   output eff_len_t                len_o
);

   dir_field_t rd_arr [NUM_CS];
   dir_field_t wr_arr [NUM_CS];
   dir_field_t pick;

   generate
      for (genvar k = 0; k < NUM_CS; k++) begin : g_unpack
         assign rd_arr[k] = cfg_i[k*CFG_W +: DIR_W];
         assign wr_arr[k] = cfg_i[k*CFG_W + DIR_W +: DIR_W];
      end
   endgenerate

   always_comb begin
      pick = rd_arr[0];
      for (int k = 0; k < NUM_CS; k++) begin
         if (int'(cs_i) == k) begin
            pick = we_i ? wr_arr[k] : rd_arr[k];
         end
      end
   end

   // A programmed zero is stretched to a single period
   always_comb begin
      len_o.setup  = min_one(CNT_W'(pick.setup));
      len_o.strobe = min_one(CNT_W'(pick.strobe));
      len_o.hold   = min_one(CNT_W'(pick.hold));
   end

endmodule

// File: rtl/amc_cycle_fsm.sv
module amc_cycle_fsm
   import amc_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       start_i,
   input  eff_len_t   len_i,
   input  logic       we_i,
   input  logic       rdy_i,
   output cyc_state_t state_o,
   output logic       first_o,
   output logic       capture_o,
   output logic       done_o,
   output logic       after_rd_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   cyc_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   eff_len_t         len_q;
   logic             first_q;
   logic             done_q;
   logic             after_rd_q;
   logic             strobe_last;

   assign strobe_last = (state_q == ST_STROBE) && (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         len_q      <= '0;
         first_q    <= 1'b0;
         done_q     <= 1'b0;
         after_rd_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         first_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               after_rd_q <= 1'b0;
               if (start_i) begin
                  len_q   <= len_i;
                  cnt_q   <= len_i.setup - ONE;
                  state_q <= ST_SETUP;
                  first_q <= 1'b1;
               end
            end
            ST_SETUP: begin
               if (cnt_q == '0) begin
                  state_q <= ST_STROBE;
                  cnt_q   <= len_q.strobe - ONE;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
            ST_STROBE: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - ONE;
               end else if (rdy_i) begin
                  state_q <= ST_HOLD;
                  cnt_q   <= len_q.hold - ONE;
               end
            end
            ST_HOLD: begin
               if (cnt_q == '0) begin
                  state_q    <= ST_IDLE;
                  done_q     <= 1'b1;
                  after_rd_q <= !we_i;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o    = state_q;
   assign first_o    = first_q;
   assign capture_o  = strobe_last && rdy_i;
   assign done_o     = done_q;
   assign after_rd_o = after_rd_q;

   // Checker-side age of the setup phase
   logic [CNT_W-1:0] age_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) age_q <= '0;
      else         age_q <= (state_q == ST_SETUP) ? age_q + ONE : '0;
   end

   assert_setup_span_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_STROBE && $past(state_q) == ST_SETUP)
         |-> ($past(age_q) == $past(len_q.setup) - ONE));

   assert_strobe_stretch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_last && !rdy_i) |=> (state_q == ST_STROBE));

   assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);

   assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> (state_q == ST_IDLE));

endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl
   import amc_pkg::*;
#(
   parameter  int NUM_CS      = 4,
   parameter  int AW          = 20,
   parameter  int DW          = 32,
   parameter  int SYNC_STAGES = 2,
   localparam int CS_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int BEW         = DW / 8
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [NUM_CS*CFG_W-1:0] cs_timing_i,
   input  logic                    req_valid_i,
   output logic                    req_ready_o,
   input  logic [CS_W-1:0]         req_cs_i,
   input  logic                    req_we_i,
   input  logic [AW-1:0]           req_addr_i,
   input  logic [BEW-1:0]          req_be_i,
   input  logic [DW-1:0]           req_wdata_i,
   output logic                    done_o,
   output logic [DW-1:0]           done_rdata_o,
   output logic [NUM_CS-1:0]       mem_ce_no,
   output logic [AW-1:0]           mem_addr_o,
   output logic [BEW-1:0]          mem_be_no,
   output logic                    mem_oe_no,
   output logic                    mem_rd_no,
   output logic                    mem_wr_no,
   output logic [DW-1:0]           mem_dq_o,
   output logic                    mem_dq_oe_o,
   input  logic [DW-1:0]           mem_dq_i,
   input  logic                    mem_rdy_i
);

   generate
      if (NUM_CS < 1) begin : g_bad_cs
         $error("amc_ctrl: NUM_CS must be at least one");
      end
      if (AW < 1) begin : g_bad_aw
         $error("amc_ctrl: AW must be at least one");
      end
      if ((DW % 8) != 0 || DW < 8) begin : g_bad_dw
         $error("amc_ctrl: DW must be a whole number of bytes");
      end
   endgenerate

   // ---------------- request capture ----------------
   logic             accept;
   logic [CS_W-1:0]  cs_q;
   logic             we_q;
   logic [AW-1:0]    addr_q;
   logic [BEW-1:0]   be_q;
   logic [DW-1:0]    wdata_q;
   logic [DW-1:0]    rdata_q;

   cyc_state_t state;
   logic       first;
   logic       capture;
   logic       after_rd;
   logic       rdy_sync;
   eff_len_t   req_len;
   logic       busy;

   assign req_ready_o = (state == ST_IDLE) && !(after_rd && req_we_i);
   assign accept      = req_valid_i && req_ready_o;
   assign busy        = (state != ST_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_q    <= '0;
         we_q    <= 1'b0;
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         cs_q    <= req_cs_i;
         we_q    <= req_we_i;
         addr_q  <= req_addr_i;
         be_q    <= req_be_i;
         wdata_q <= req_wdata_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_q <= '0;
      else if (capture) rdata_q <= mem_dq_i;
   end

   // ---------------- sub-blocks ----------------
   amc_timing_sel #(.NUM_CS(NUM_CS)) u_sel (
      .cfg_i (cs_timing_i),
      .cs_i  (req_cs_i),
      .we_i  (req_we_i),
      .len_o (req_len)
   );

   amc_ready_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (mem_rdy_i),
      .sync_o  (rdy_sync)
   );

   amc_cycle_fsm u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (accept),
      .len_i      (req_len),
      .we_i       (we_q),
      .rdy_i      (rdy_sync),
      .state_o    (state),
      .first_o    (first),
      .capture_o  (capture),
      .done_o     (done_o),
      .after_rd_o (after_rd)
   );

   // ---------------- pin decode ----------------
   generate
      for (genvar k = 0; k < NUM_CS; k++) begin : g_ce
         assign mem_ce_no[k] = !(busy && (int'(cs_q) == k));
      end
   endgenerate

   assign mem_addr_o   = addr_q;
   assign mem_be_no    = busy ? ~be_q : '1;
   assign mem_oe_no    = !(busy && !we_q);
   assign mem_rd_no    = !((state == ST_STROBE) && !we_q);
   assign mem_wr_no    = !((state == ST_STROBE) && we_q);
   assign mem_dq_o     = wdata_q;
   assign mem_dq_oe_o  = we_q && (((state == ST_SETUP) && !first) ||
                                  (state == ST_STROBE) || (state == ST_HOLD));
   assign done_rdata_o = rdata_q;

   // ---------------- assertions ----------------
   assert_busy_no_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o) |=> !req_ready_o);

   assert_turnaround_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !we_q && req_we_i) |-> !req_ready_o);

   assert_no_contention_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_dq_oe_o |-> mem_oe_no);

   assert_data_before_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(mem_wr_no) |-> mem_dq_oe_o);

   assert_strobe_has_select_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mem_rd_no || !mem_wr_no) |-> (mem_ce_no != '1));

   assert_addr_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && $past(busy)) |-> ($stable(mem_addr_o) && $stable(mem_ce_no)));

   assert_write_oe_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mem_wr_no) |-> mem_oe_no);

endmodule

// File: tb/amc_ctrl_bench.sv
module amc_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NCS = 4;
   localparam int WORD_W = 26;

   logic                  clk_i = 1'b0;
   logic                  rst_ni = 1'b0;
   logic [NCS*WORD_W-1:0] cs_timing_i;
   logic                  req_valid_i = 1'b0;
   logic                  req_ready_o;
   logic [1:0]            req_cs_i = '0;
   logic                  req_we_i = 1'b0;
   logic [19:0]           req_addr_i = '0;
   logic [3:0]            req_be_i = '0;
   logic [31:0]           req_wdata_i = '0;
   logic                  done_o;
   logic [31:0]           done_rdata_o;
   logic [NCS-1:0]        mem_ce_no;
   logic [19:0]           mem_addr_o;
   logic [3:0]            mem_be_no;
   logic                  mem_oe_no, mem_rd_no, mem_wr_no;
   logic [31:0]           mem_dq_o;
   logic                  mem_dq_oe_o;
   logic [31:0]           mem_dq_i = '0;
   logic                  mem_rdy_i = 1'b1;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   amc_ctrl u_amc_ctrl (.*);

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   always @(posedge clk_i) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [12:0] dir_word(input int s, input int t, input int h);
      return {3'(h), 6'(t), 4'(s)};
   endfunction

   task automatic set_cs(input int k, input logic [12:0] rd, input logic [12:0] wr);
      cs_timing_i[k*WORD_W +: WORD_W] = {wr, rd};
   endtask

   // Runs one access starting at a negedge; returns at the negedge of its done period
   task automatic run_acc(input string tag, input int cs, input bit we,
                          input logic [19:0] a, input logic [3:0] be, input logic [31:0] wd,
                          input int es, input int et, input int eh,
                          input int low_at, input int high_at,
                          input logic [31:0] da, input logic [31:0] db,
                          output int waits, output logic [31:0] rdat);
      int n_set = 0, n_str = 0, n_hold = 0, n_lead = 0, n_sdq = 0, n_hdq = 0;
      int phase = 0, guard = 0;
      bit sel_bad = 0, oe_bad = 0, busy_bad = 0, dat_bad = 0, stb;
      req_cs_i = 2'(cs); req_we_i = we; req_addr_i = a; req_be_i = be;
      req_wdata_i = wd; req_valid_i = 1'b1;
      #1;
      waits = 0;
      while (!req_ready_o && waits < 50) begin
         @(negedge clk_i); #1; waits++;
      end
      @(negedge clk_i);
      req_valid_i = 1'b0;
      while (mem_ce_no != '1 && guard < 500) begin
         stb = we ? !mem_wr_no : !mem_rd_no;
         if (mem_ce_no != 4'(~(4'b0001 << cs)) || mem_addr_o != a || mem_be_no != ~be) sel_bad = 1;
         if (mem_oe_no != we) oe_bad = 1;
         if (req_ready_o) busy_bad = 1;
         if (!we && mem_dq_oe_o) dat_bad = 1;
         if (we && mem_dq_oe_o && mem_dq_o != wd) dat_bad = 1;
         if (stb) begin
            phase = 1; n_str++;
            if (mem_dq_oe_o) n_sdq++;
            if (n_str == 1 && !we) mem_dq_i = da;
            if (n_str == low_at) mem_rdy_i = 1'b0;
            if (n_str == high_at) mem_rdy_i = 1'b1;
         end else if (phase == 0) begin
            n_set++;
            if (mem_dq_oe_o) n_lead++;
         end else begin
            if (phase == 1) mem_dq_i = db;
            phase = 2; n_hold++;
            if (mem_dq_oe_o) n_hdq++;
         end
         @(negedge clk_i);
         guard++;
      end
      rdat = done_rdata_o;
      chk(done_o == 1'b1, "R8", "done in period after hold", done_o, 1);
      chk(n_set == es, tag, "setup periods", n_set, es);
      chk(n_str == et, tag, "strobe periods", n_str, et);
      chk(n_hold == eh, tag, "hold periods", n_hold, eh);
      chk(!sel_bad, "R11", "select/address/byte-enable mismatch", sel_bad, 0);
      chk(!oe_bad, we ? "R3" : "R2", "output enable level", oe_bad, 0);
      chk(!busy_bad, "R9", "ready while busy", busy_bad, 0);
      chk(!dat_bad, "R5", "data bus drive/value", dat_bad, 0);
      if (we) begin
         chk(n_lead == es - 1, "R5", "data lead periods", n_lead, es - 1);
         chk(n_sdq == n_str, "R5", "data during strobe", n_sdq, n_str);
         chk(n_hdq == eh, "R5", "data during hold", n_hdq, eh);
      end
   endtask

   task automatic t_reset_r1;
      chk(mem_ce_no == '1, "R1", "chip enables", mem_ce_no, 15);
      chk(mem_rd_no && mem_wr_no, "R1", "strobes high", {mem_rd_no, mem_wr_no}, 3);
      chk(mem_oe_no == 1'b1, "R1", "output enable", mem_oe_no, 1);
      chk(mem_dq_oe_o == 1'b0, "R1", "data drive", mem_dq_oe_o, 0);
      chk(done_o == 1'b0, "R1", "done", done_o, 0);
      chk(req_ready_o == 1'b1, "R1", "ready", req_ready_o, 1);
   endtask

   task automatic t_read_r2_r7;
      int w; logic [31:0] rd;
      run_acc("R2", 0, 1'b0, 20'h1A2B3, 4'b1011, 32'h0, 3, 4, 2, 0, 0,
              32'hCAFE_0123, 32'h5555_AAAA, w, rd);
      chk(rd == 32'hCAFE_0123, "R7", "read data captured at strobe end", rd, 32'hCAFE_0123);
      @(negedge clk_i);
      chk(done_o == 1'b0, "R8", "done is one period", done_o, 0);
   endtask

   task automatic t_write_r3_r5;
      int w; logic [31:0] rd;
      run_acc("R3", 1, 1'b1, 20'h0F00F, 4'b0110, 32'hDEAD_BEEF, 4, 5, 2, 0, 0,
              32'h0, 32'h0, w, rd);
      @(negedge clk_i);
      chk(mem_dq_oe_o == 1'b0, "R5", "data released after write", mem_dq_oe_o, 0);
   endtask

   task automatic t_zero_r4;
      int w; logic [31:0] rd;
      run_acc("R4", 2, 1'b0, 20'h00001, 4'b1111, 32'h0, 1, 1, 1, 0, 0,
              32'h1357_9BDF, 32'h0, w, rd);
      chk(rd == 32'h1357_9BDF, "R7", "read data with unit strobe", rd, 32'h1357_9BDF);
      run_acc("R4", 2, 1'b1, 20'hFFFFF, 4'b0001, 32'h0BAD_F00D, 1, 1, 1, 0, 0,
              32'h0, 32'h0, w, rd);
      @(negedge clk_i);
   endtask

   task automatic t_ready_r6;
      int w; logic [31:0] rd;
      // Not-ready from before the request, released after six strobe periods
      mem_rdy_i = 1'b0;
      run_acc("R6", 3, 1'b0, 20'h00ABC, 4'b1100, 32'h0, 2, 8, 1, 0, 6,
              32'h2468_ACE0, 32'h0, w, rd);
      chk(rd == 32'h2468_ACE0, "R7", "read data after stretched strobe", rd, 32'h2468_ACE0);
      @(negedge clk_i);
      // Short not-ready early in a ten-period strobe is ignored
      set_cs(3, dir_word(2, 10, 1), dir_word(1, 1, 1));
      run_acc("R6", 3, 1'b0, 20'h00ABD, 4'b0011, 32'h0, 2, 10, 1, 1, 3,
              32'h1111_2222, 32'h0, w, rd);
      @(negedge clk_i);
      set_cs(3, dir_word(2, 2, 1), dir_word(1, 1, 1));
   endtask

   task automatic t_chain_r8_r10;
      int w; logic [31:0] rd;
      run_acc("R2", 0, 1'b0, 20'h00010, 4'b1111, 32'h0, 3, 4, 2, 0, 0,
              32'hA0A0_A0A0, 32'h0, w, rd);
      // Write presented in the done period of a read waits one period
      run_acc("R3", 1, 1'b1, 20'h00020, 4'b1111, 32'h7777_8888, 4, 5, 2, 0, 0,
              32'h0, 32'h0, w, rd);
      chk(w == 1, "R10", "waits for write after read", w, 1);
      // Read right after write: accepted in the done period
      run_acc("R2", 3, 1'b0, 20'h00030, 4'b0101, 32'h0, 2, 2, 1, 0, 0,
              32'hB1B1_B1B1, 32'h0, w, rd);
      chk(w == 0, "R8", "waits for read after write", w, 0);
      // Read right after read: accepted in the done period
      run_acc("R2", 0, 1'b0, 20'h00040, 4'b1010, 32'h0, 3, 4, 2, 0, 0,
              32'hC2C2_C2C2, 32'h0, w, rd);
      chk(w == 0, "R10", "waits for read after read", w, 0);
      chk(rd == 32'hC2C2_C2C2, "R7", "back-to-back read data", rd, 32'hC2C2_C2C2);
      run_acc("R3", 3, 1'b1, 20'h00050, 4'b1001, 32'h1234_5678, 1, 1, 1, 0, 0,
              32'h0, 32'h0, w, rd);
      chk(w == 1, "R10", "waits for write after read (second)", w, 1);
      // Write right after write: accepted in the done period
      run_acc("R3", 1, 1'b1, 20'h00060, 4'b1111, 32'h8765_4321, 4, 5, 2, 0, 0,
              32'h0, 32'h0, w, rd);
      chk(w == 0, "R8", "waits for write after write", w, 0);
      @(negedge clk_i);
      chk(done_o == 1'b0 && req_ready_o == 1'b1, "R8", "idle after chain",
          {done_o, req_ready_o}, 1);
   endtask

   initial begin
      cs_timing_i = '0;
      set_cs(0, dir_word(3, 4, 2), dir_word(2, 3, 1));
      set_cs(1, dir_word(1, 2, 3), dir_word(4, 5, 2));
      set_cs(2, dir_word(0, 0, 0), dir_word(0, 0, 0));
      set_cs(3, dir_word(2, 2, 1), dir_word(1, 1, 1));
      repeat (3) @(negedge clk_i);
      t_reset_r1();
      rst_ni = 1'b1;
      repeat (3) @(negedge clk_i);
      t_reset_r1();
      t_read_r2_r7();
      t_write_r3_r5();
      t_zero_r4();
      t_ready_r6();
      t_chain_r8_r10();
      repeat (2) @(negedge clk_i);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule